// File: doc/BRIEF.md
# Four-Channel Shelving Pre-Emphasis Filter with Level Flags

This block sits in front of an automatic gain loop in an audio datapath. Samples for four channels arrive one at a time as a 24-bit word, a channel index and a valid strobe. Each enabled channel runs through its own first-order IIR stage that has one pole and one zero, H(z) = (A + C·z⁻¹)/(1 + B·z⁻¹). The stage is followed by a programmable attenuation that sets the overall gain. The pole sits at 150 Hz and the zero at 100 Hz. The coefficient set comes from a two-bit sample-rate range code, so the corner frequencies stay fixed as the rate changes.

The filtered result is compared against two programmable magnitudes. One is the level at which the limiter should engage, the other the level that restarts the recovery timer. A separate detector looks at the raw input for clipping. Each of these events sets a sticky per-channel flag that a clear strobe wipes. Full scale (0 dBFS) is a magnitude of 2^22, which leaves one bit of headroom in the 24-bit word. When the bypass bit is set, samples pass through unchanged after the same latency and no detector fires. A disabled channel produces zero data.

Top module: `ml_shelf_eq`

## Requirements
- R1: For an enabled, unbypassed sample x on channel c, the filtered value is y = sat(round((A·x + C·x1 − B·y1)/2^22)), where x1 and y1 are the previous x and y of that channel. The state starts at zero. Rounding adds 2^21 and then takes the floor.
- R2: Coefficients are Q2.22 integers (A, B, C), selected by the rate code at sample time. Code 11 selects (6213912, −3877173, −5896781). Code 01 selects (6251517, −4032748, −6089961). Codes 00 and 10 both select (6271189, −4112746, −6189631).
- R3: The output is sat(round(G·y/2^22)), where G is selected by gain_code: 0 gives 4194304 (0 dB), 1 gives 2102132 (−6 dB), 2 gives 1053561 (−12 dB), 3 gives 528031 (−18 dB). The output magnitude never exceeds |y|.
- R4: Every rounding step saturates to the 24-bit range −8388608..8388607.
- R5: A sample accepted at a clock edge appears on out_valid/out_ch/out_data exactly two edges later, in every mode. Samples may arrive on every cycle in any channel order.
- R6: With eq_bypass = 1, out_data equals the input sample, no flag is set, and all channel state is cleared.
- R7: A sample on a channel whose chan_en bit is 0 gives out_data = 0 and sets no flag. That channel's state is held at zero while it is disabled.
- R8: Any change of rate_code clears the state of every channel at the next edge.
- R9: clip_flag[c] is set when an enabled, unbypassed sample on c has a magnitude greater than 4458199 (+0.53 dBFS).
- R10: lim_flag[c] is set when the output magnitude of an enabled, unbypassed sample on c is greater than lim_thr.
- R11: rec_flag[c] is set when that output magnitude is greater than rec_thr.
- R12: Flags rise in the same cycle that the sample's output is valid. They stay set until flag_clr. A clear and a new event at the same edge leave the new event set.
- R13: During reset, out_valid, out_data and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_ch | input | 2 | Channel index of the input sample |
| in_data | input | 24 | Input sample, two's complement |
| rate_code | input | 2 | Sample-rate range code |
| eq_bypass | input | 1 | 1 = pass samples through, detectors off |
| gain_code | input | 2 | Attenuation step, −6 dB per step |
| chan_en | input | 4 | Per-channel enable |
| lim_thr | input | 24 | Limiter threshold magnitude |
| rec_thr | input | 24 | Recovery reset threshold magnitude |
| flag_clr | input | 1 | Clears all sticky flags |
| out_valid | output | 1 | Output sample strobe |
| out_ch | output | 2 | Channel index of the output sample |
| out_data | output | 24 | Output sample |
| lim_flag | output | 4 | Sticky limiter-threshold flags |
| rec_flag | output | 4 | Sticky recovery-level flags |
| clip_flag | output | 4 | Sticky input clip flags |

## Verification
Bad per-channel state does not stay hidden. A state word that is not cleared, or that is stored under the wrong channel, shows up as a wrong out_data on the next sample of that channel, two edges after that sample enters. A coefficient taken from the wrong set or a wrong rounding step shows up the same way. Through the pole term, the error then persists across the following samples. A detector fault appears as a flag bit that differs from the model in the same cycle as the output word. A lost sticky bit appears on the first cycle after it drops, so the bench compares the flags on every clock rather than only at the end.

// File: rtl/ml_shelf_eq_pkg.sv
package ml_shelf_eq_pkg;
   localparam int SMP_W     = 24;
   localparam int COEF_W    = 24;
   localparam int COEF_FRAC = 22;
   localparam int ACC_W     = SMP_W + COEF_W + 2;

   typedef logic signed [COEF_W-1:0] coef_t;
   typedef struct packed {
      coef_t a;
      coef_t b;
      coef_t c;
   } coef_set_t;

   // +0.53 dBFS with full scale at 2^22
   localparam logic [SMP_W-1:0] CLIP_LVL = 24'd4458199;

   localparam logic signed [ACC_W-1:0] SAT_HI = (ACC_W'(1) <<< (SMP_W-1)) - ACC_W'(1);
   localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

   function automatic coef_set_t coef_for_rate(input logic [1:0] code);
      coef_set_t r;
      case (code)
         2'b11: begin
            r.a = 24'sd6213912;  r.b = -24'sd3877173; r.c = -24'sd5896781;
         end
         2'b01: begin
            r.a = 24'sd6251517;  r.b = -24'sd4032748; r.c = -24'sd6089961;
         end
         default: begin
            r.a = 24'sd6271189;  r.b = -24'sd4112746; r.c = -24'sd6189631;
         end
      endcase
      return r;
   endfunction

   function automatic coef_t gain_for(input logic [1:0] k);
      case (k)
         2'd0:    return 24'sd4194304;
         2'd1:    return 24'sd2102132;
         2'd2:    return 24'sd1053561;
         default: return 24'sd528031;
      endcase
   endfunction

   function automatic logic signed [SMP_W-1:0] rsat(input logic signed [ACC_W-1:0] v,
                                                     input logic rnd);
      logic signed [ACC_W-1:0] half;
      logic signed [ACC_W-1:0] r;
      half = '0;
      half[COEF_FRAC-1] = rnd;
      r = (v + half) >>> COEF_FRAC;
      if (r > SAT_HI)      return SAT_HI[SMP_W-1:0];
      else if (r < SAT_LO) return SAT_LO[SMP_W-1:0];
      else                 return r[SMP_W-1:0];
   endfunction

   function automatic logic [SMP_W-1:0] mag(input logic signed [SMP_W-1:0] v);
      return v[SMP_W-1] ? SMP_W'(-v) : v;
   endfunction
endpackage

// File: rtl/ml_shelf_eq_mac.sv
module ml_shelf_eq_mac
   import ml_shelf_eq_pkg::*;
#(
   parameter int ROUND_NEAREST = 1
) (
   input  coef_set_t                cs,
   input  coef_t                    gain,
   input  logic signed [SMP_W-1:0]  x,
   input  logic signed [SMP_W-1:0]  x1,
   input  logic signed [SMP_W-1:0]  y1,
   output logic signed [SMP_W-1:0]  y_filt,
   output logic signed [SMP_W-1:0]  y_out
);
   logic rnd;
   generate
      if (ROUND_NEAREST != 0) begin : g_nearest
         assign rnd = 1'b1;
      end else begin : g_trunc
         assign rnd = 1'b0;
      end
   endgenerate

   logic signed [ACC_W-1:0] ea, eb, ec, eg, ex, ex1, ey1, eyf;
   logic signed [ACC_W-1:0] acc_f, acc_g;

   always_comb begin
      ea    = ACC_W'(cs.a);
      eb    = ACC_W'(cs.b);
      ec    = ACC_W'(cs.c);
      eg    = ACC_W'(gain);
      ex    = ACC_W'(x);
      ex1   = ACC_W'(x1);
      ey1   = ACC_W'(y1);
      acc_f = ea * ex + ec * ex1 - eb * ey1;
      y_filt = rsat(acc_f, rnd);
      eyf   = ACC_W'(y_filt);
      acc_g = eg * eyf;
      y_out = rsat(acc_g, rnd);
   end

   always_comb begin
      AST_GAIN_NO_BOOST: assert (mag(y_out) <= mag(y_filt)); // R3
   end
endmodule

// File: rtl/ml_shelf_eq_flags.sv
module ml_shelf_eq_flags #(
   parameter int NCH  = 4,
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            ev_valid,
   input  logic [CH_W-1:0] ev_ch,
   input  logic            ev_lim,
   input  logic            ev_rec,
   input  logic            ev_clip,
   output logic [NCH-1:0]  lim_flag,
   output logic [NCH-1:0]  rec_flag,
   output logic [NCH-1:0]  clip_flag
);
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic hit, l_q, r_q, k_q;
         assign hit = ev_valid && (ev_ch == CH_W'(c));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               l_q <= 1'b0;
               r_q <= 1'b0;
               k_q <= 1'b0;
            end else begin
               l_q <= (l_q & ~clr) | (hit & ev_lim);
               r_q <= (r_q & ~clr) | (hit & ev_rec);
               k_q <= (k_q & ~clr) | (hit & ev_clip);
            end
         end
         assign lim_flag[c]  = l_q;
         assign rec_flag[c]  = r_q;
         assign clip_flag[c] = k_q;
      end
   endgenerate

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((lim_flag & $past(lim_flag)) == $past(lim_flag)) &&
               ((rec_flag & $past(rec_flag)) == $past(rec_flag)) &&
               ((clip_flag & $past(clip_flag)) == $past(clip_flag))); // R12
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !ev_valid |=> (lim_flag == '0) && (rec_flag == '0) && (clip_flag == '0)); // R12
   AST_FLAG_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> ((lim_flag & ~$past(lim_flag)) == '0) &&
                    ((rec_flag & ~$past(rec_flag)) == '0) &&
                    ((clip_flag & ~$past(clip_flag)) == '0)); // R12
endmodule

// File: rtl/ml_shelf_eq.sv
module ml_shelf_eq
   import ml_shelf_eq_pkg::*;
#(
   parameter int SMP_BITS      = 24,
   parameter int NCH           = 4,
   parameter int CH_W          = $clog2(NCH),
   parameter int ROUND_NEAREST = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [CH_W-1:0]      in_ch,
   input  logic [SMP_BITS-1:0]  in_data,
   input  logic [1:0]           rate_code,
   input  logic                 eq_bypass,
   input  logic [1:0]           gain_code,
   input  logic [NCH-1:0]       chan_en,
   input  logic [SMP_BITS-1:0]  lim_thr,
   input  logic [SMP_BITS-1:0]  rec_thr,
   input  logic                 flag_clr,
   output logic                 out_valid,
   output logic [CH_W-1:0]      out_ch,
   output logic [SMP_BITS-1:0]  out_data,
   output logic [NCH-1:0]       lim_flag,
   output logic [NCH-1:0]       rec_flag,
   output logic [NCH-1:0]       clip_flag
);
   generate
      if (SMP_BITS != SMP_W) begin : g_bad_width
         $error("ml_shelf_eq: SMP_BITS must match the coefficient package sample width");
      end
      if ((1 << CH_W) != NCH) begin : g_bad_nch
         $error("ml_shelf_eq: NCH must be a power of two matching CH_W");
      end
   endgenerate

   // stage 1: sample and the configuration it was issued under
   logic                     s1_v, s1_en, s1_byp;
   logic [CH_W-1:0]          s1_ch;
   logic signed [SMP_W-1:0]  s1_x;
   logic [1:0]               s1_rate, s1_gain;
   logic [1:0]               rate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v <= 1'b0; s1_en <= 1'b0; s1_byp <= 1'b0;
         s1_ch <= '0;  s1_x <= '0;
         s1_rate <= '0; s1_gain <= '0; rate_q <= '0;
      end else begin
         s1_v    <= in_valid;
         s1_ch   <= in_ch;
         s1_x    <= in_data;
         s1_en   <= chan_en[in_ch];
         s1_byp  <= eq_bypass;
         s1_rate <= rate_code;
         s1_gain <= gain_code;
         rate_q  <= rate_code;
      end
   end

   // per-channel z^-1 state
   logic signed [SMP_W-1:0] x1_q [NCH];
   logic signed [SMP_W-1:0] y1_q [NCH];
   logic signed [SMP_W-1:0] y_filt, y_out;
   logic flush_all, upd;

   assign flush_all = eq_bypass || (rate_code != rate_q);
   assign upd       = s1_v && s1_en && !s1_byp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            x1_q[c] <= '0;
            y1_q[c] <= '0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (flush_all || !chan_en[c]) begin
               x1_q[c] <= '0;
               y1_q[c] <= '0;
            end else if (upd && (s1_ch == CH_W'(c))) begin
               x1_q[c] <= s1_x;
               y1_q[c] <= y_filt;
            end
         end
      end
   end

   ml_shelf_eq_mac #(.ROUND_NEAREST(ROUND_NEAREST)) u_mac (
      .cs     (coef_for_rate(s1_rate)),
      .gain   (gain_for(s1_gain)),
      .x      (s1_x),
      .x1     (x1_q[s1_ch]),
      .y1     (y1_q[s1_ch]),
      .y_filt (y_filt),
      .y_out  (y_out)
   );

   // result select and level events
   logic signed [SMP_W-1:0] res;
   logic ev_lim, ev_rec, ev_clip;

   always_comb begin
      if (!s1_en)      res = '0;
      else if (s1_byp) res = s1_x;
      else             res = y_out;
      ev_lim  = upd && (mag(y_out) > lim_thr);
      ev_rec  = upd && (mag(y_out) > rec_thr);
      ev_clip = upd && (mag(s1_x) > CLIP_LVL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ch    <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= s1_v;
         out_ch    <= s1_ch;
         out_data  <= s1_v ? res : '0;
      end
   end

   ml_shelf_eq_flags #(.NCH(NCH), .CH_W(CH_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (flag_clr),
      .ev_valid  (s1_v),
      .ev_ch     (s1_ch),
      .ev_lim    (ev_lim),
      .ev_rec    (ev_rec),
      .ev_clip   (ev_clip),
      .lim_flag  (lim_flag),
      .rec_flag  (rec_flag),
      .clip_flag (clip_flag)
   );

   logic [NCH-1:0] st_nz;
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_nz
         assign st_nz[c] = (x1_q[c] != '0) || (y1_q[c] != '0);
      end
   endgenerate

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid); // R5
   AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      s1_v && !s1_en |=> out_valid && (out_data == '0)); // R7
   AST_BYPASS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      s1_v && s1_en && s1_byp |=> out_data == $past(s1_x)); // R6
   AST_BYPASS_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      s1_v && s1_byp |=> (((lim_flag | rec_flag | clip_flag) &
                           ~$past(lim_flag | rec_flag | clip_flag)) == '0)); // R6
   AST_RATE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      rate_code != rate_q |=> st_nz == '0); // R8
   AST_OFF_CHANNEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (st_nz & ~$past(chan_en)) == '0); // R7
endmodule

// File: tb/ml_shelf_eq_bench.sv
module ml_shelf_eq_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        in_valid = 1'b0;
   logic [1:0]  in_ch = '0;
   logic [23:0] in_data = '0;
   logic [1:0]  rate_code = '0;
   logic        eq_bypass = 1'b0;
   logic [1:0]  gain_code = '0;
   logic [3:0]  chan_en = 4'hF;
   logic [23:0] lim_thr = 24'hFFFFFF;
   logic [23:0] rec_thr = 24'hFFFFFF;
   logic        flag_clr = 1'b0;
   logic        out_valid;
   logic [1:0]  out_ch;
   logic [23:0] out_data;
   logic [3:0]  lim_flag, rec_flag, clip_flag;

   ml_shelf_eq u_ml_shelf_eq (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
      .rate_code(rate_code), .eq_bypass(eq_bypass), .gain_code(gain_code),
      .chan_en(chan_en), .lim_thr(lim_thr), .rec_thr(rec_thr), .flag_clr(flag_clr),
      .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data),
      .lim_flag(lim_flag), .rec_flag(rec_flag), .clip_flag(clip_flag)
   );

   typedef struct {
      int     due;
      int     ch;
      longint data;
      bit     l, r, k;
   } exp_t;

   exp_t   expq[$];
   int     n_cmp = 0, n_bad = 0, stepn = 0;
   bit     done = 0, pend_clr = 0;
   string  cur_req = "R13";
   longint mx1[4], my1[4];
   bit [3:0] ml = 0, mr = 0, mk = 0;
   bit [1:0] cur_rate = 0;

   bit [1:0]  nx_rate = 0, nx_gain = 0;
   bit        nx_byp = 0;
   bit [3:0]  nx_en = 4'hF;
   bit [23:0] nx_lim = 24'hFFFFFF, nx_rec = 24'hFFFFFF;

   function automatic longint rs(longint v);
      longint r;
      r = (v + 64'sd2097152) >>> 22;
      if (r > 64'sd8388607) r = 64'sd8388607;
      if (r < -64'sd8388608) r = -64'sd8388608;
      return r;
   endfunction

   function automatic longint absl(longint v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic longint coef(bit [1:0] rate, int which);
      longint t[3];
      if (rate == 2'b11)      t = '{6213912, -3877173, -5896781};
      else if (rate == 2'b01) t = '{6251517, -4032748, -6089961};
      else                    t = '{6271189, -4112746, -6189631};
      return t[which];
   endfunction

   function automatic longint gain_of(bit [1:0] k);
      longint g[4] = '{4194304, 2102132, 1053561, 528031};
      return g[k];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s step %0d: got %0d expected %0d", req, what, stepn, act, expv);
      end
   endtask

   task automatic check_out();
      exp_t e;
      bit has;
      if (pend_clr) begin
         ml = 0; mr = 0; mk = 0; pend_clr = 0;
      end
      has = (expq.size() != 0) && (expq[0].due == stepn);
      chk(out_valid == has, "R5", "out_valid", longint'(out_valid), longint'(has));
      if (has) begin
         e = expq.pop_front();
         chk(int'(out_ch) == e.ch, "R5", "out_ch", longint'(out_ch), longint'(e.ch));
         chk(longint'($signed(out_data)) == e.data, cur_req, "out_data",
             longint'($signed(out_data)), e.data);
         ml[e.ch] = ml[e.ch] | e.l;
         mr[e.ch] = mr[e.ch] | e.r;
         mk[e.ch] = mk[e.ch] | e.k;
      end
      chk({lim_flag, rec_flag, clip_flag} == {ml, mr, mk}, cur_req, "flags lim/rec/clip",
          longint'({lim_flag, rec_flag, clip_flag}), longint'({ml, mr, mk}));
      stepn++;
   endtask

   task automatic step(input bit v, input int ch, input longint x, input bit clr);
      exp_t e;
      longint y, o;
      @(negedge clk);
      check_out();
      in_valid  = v;
      in_ch     = ch[1:0];
      in_data   = x[23:0];
      flag_clr  = clr;
      rate_code = nx_rate;
      eq_bypass = nx_byp;
      gain_code = nx_gain;
      chan_en   = nx_en;
      lim_thr   = nx_lim;
      rec_thr   = nx_rec;
      if (clr) pend_clr = 1;
      if (nx_byp || (nx_rate != cur_rate))
         for (int c = 0; c < 4; c++) begin mx1[c] = 0; my1[c] = 0; end
      cur_rate = nx_rate;
      for (int c = 0; c < 4; c++)
         if (!nx_en[c]) begin mx1[c] = 0; my1[c] = 0; end
      if (v) begin
         e.due = stepn + 1; e.ch = ch; e.l = 0; e.r = 0; e.k = 0;
         if (!nx_en[ch])  e.data = 0;
         else if (nx_byp) e.data = x;
         else begin
            y = rs(coef(nx_rate, 0) * x + coef(nx_rate, 2) * mx1[ch] - coef(nx_rate, 1) * my1[ch]);
            o = rs(gain_of(nx_gain) * y);
            mx1[ch] = x; my1[ch] = y;
            e.data = o;
            e.l = absl(o) > longint'(nx_lim);
            e.r = absl(o) > longint'(nx_rec);
            e.k = absl(x) > 64'sd4458199;
         end
         expq.push_back(e);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, got 0 expected 1");
      finish_run();
   end

   initial begin
      for (int c = 0; c < 4; c++) begin mx1[c] = 0; my1[c] = 0; end
      // R13: reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R13", "reset out_valid", longint'(out_valid), 0);
      chk(out_data == '0, "R13", "reset out_data", longint'(out_data), 0);
      chk({lim_flag, rec_flag, clip_flag} == '0, "R13", "reset flags",
          longint'({lim_flag, rec_flag, clip_flag}), 0);
      rst_n = 1'b1;
      idle(2);

      // R1: impulse and step on interleaved channels
      cur_req = "R1";
      step(1, 0, 1000000, 0);
      for (int i = 0; i < 6; i++) begin
         step(1, 1, 500000, 0);
         step(1, 0, 0, 0);
      end
      idle(3);

      // R2: each rate code, state flushed on change
      cur_req = "R2";
      for (int r = 0; r < 3; r++) begin
         nx_rate = (r == 0) ? 2'b01 : (r == 1) ? 2'b11 : 2'b10;
         step(1, 2, 2000000, 0);
         for (int i = 0; i < 5; i++) step(1, 2, 0, 0);
      end
      nx_rate = 2'b00;
      idle(3);

      // R3: attenuation steps
      cur_req = "R3";
      for (int g = 1; g < 4; g++) begin
         nx_gain = g[1:0];
         step(1, 3, 3000000, 0);
         step(1, 3, -3000000, 0);
         step(1, 3, 0, 0);
      end
      nx_gain = 0;
      idle(3);

      // R4: full-scale alternation saturates
      cur_req = "R4";
      for (int i = 0; i < 6; i++) step(1, 3, (i % 2) ? 8388607 : -8388608, 0);
      idle(3);

      // R8: rate change mid-stream clears state
      cur_req = "R8";
      step(1, 0, 4000000, 0);
      step(1, 0, 4000000, 0);
      nx_rate = 2'b01;
      step(1, 0, 4000000, 0);
      step(1, 0, 4000000, 0);
      nx_rate = 2'b00;
      step(1, 0, 1000, 0);
      idle(3);
      step(0, 0, 0, 1);
      idle(2);

      // R7: disabled channel outputs zero, no clip flag, state cleared
      cur_req = "R7";
      step(1, 1, 3000000, 0);
      step(1, 1, 3000000, 0);
      nx_en = 4'b1101;
      step(1, 1, 6000000, 0);
      step(1, 1, 3000000, 0);
      nx_en = 4'hF;
      step(1, 1, 3000000, 0);
      step(1, 1, 3000000, 0);
      idle(3);

      // R6: bypass passes data, no flags, flushes state
      cur_req = "R6";
      step(1, 2, 1500000, 0);
      nx_byp = 1;
      step(1, 2, 8000000, 0);
      step(1, 2, -8388608, 0);
      step(1, 0, 123, 0);
      nx_byp = 0;
      step(1, 2, 100000, 0);
      idle(3);

      // R9: clip threshold boundary on raw input
      cur_req = "R9";
      nx_gain = 3;
      step(1, 0, 4458199, 0);
      idle(2);
      step(1, 0, -4458200, 0);
      step(1, 1, 4458200, 0);
      nx_gain = 0;
      idle(3);

      // R10: limiter threshold on filtered output
      nx_lim = 24'd1000000;
      idle(2);
      cur_req = "R10";
      step(1, 2, 500000, 0);
      step(1, 2, 0, 0);
      step(1, 3, 800000, 0);
      idle(3);

      // R11: recovery level on filtered output
      nx_lim = 24'hFFFFFF;
      nx_rec = 24'd600000;
      idle(2);
      cur_req = "R11";
      step(1, 0, 300000, 0);
      step(1, 0, 300000, 0);
      step(1, 1, 700000, 0);
      idle(3);

      // R12: clear, and clear coincident with a new event
      cur_req = "R12";
      step(0, 0, 0, 1);
      idle(2);
      step(1, 2, 4500000, 0);
      step(0, 0, 0, 1);
      idle(3);
      step(0, 0, 0, 1);
      idle(2);

      // R5: back-to-back samples rotating through channels
      cur_req = "R5";
      nx_rec = 24'hFFFFFF;
      for (int i = 0; i < 8; i++) step(1, i % 4, 250000 * (i + 1), 0);
      idle(4);

      finish_run();
   end
endmodule